// File: doc/BRIEF.md
# Interlaced Composite Sync Generator

This block produces the timing of a 2:1 interlaced television raster for either a 525-line or a 625-line system. It runs from one clock at 32 times the line rate. It counts clock slots inside each half line and half lines inside each frame. From that position it produces an active-low composite sync signal, a frame marker for the odd field, and horizontal and vertical drive strobes. Outside the vertical interval, composite sync carries a normal line pulse at each line start. Inside the vertical interval it carries short equalizing pulses at twice the line rate, then broad serrated vertical pulses, then another group of equalizing pulses. Each group is six half lines long. Every edge falls on a clock boundary, so the line phase runs through the vertical interval without a break.

Two synchronous request inputs move the vertical position while staying in the current field. One moves it to the first pre-equalizing pulse, the other to the first broad pulse. Use them to pull the raster onto an external frame timing. All outputs are registered, so each output shows the decode of the position held one clock earlier.

Top module: `isync_gen`

## Requirements
- R1: While `rst_n` is low, `csync_n` is 1 and `fsync`, `hdrive` and `vdrive` are 0. On the first clock edge after release, the outputs show the first clock slot of the odd field: `csync_n`=0, `fsync`=1, `hdrive`=1, `vdrive`=1.
- R2: A half line is 16 clocks. With `std_625`=0 a frame is 1050 half lines and with `std_625`=1 it is 1250, so undisturbed `fsync` pulses are 16800 or 20000 clocks apart. The select is changed only while reset is held.
- R3: Outside the vertical interval, `csync_n` is low for the first 2 clocks of every line and high for the other 30 clocks.
- R4: Field half lines 0 to 5 and 12 to 17 are equalizing half lines. In each of them `csync_n` is low for exactly the first clock only.
- R5: Field half lines 6 to 11 are broad pulses. In each of them `csync_n` is low for the first 14 clocks and high for the last 2 clocks.
- R6: The odd field starts at frame half line 0, which is a line boundary. The even field starts at frame half line 525 or 625, which is mid-line. Line starts are the even frame half lines.
- R7: `fsync` is high for exactly one clock, at the first clock of the odd field. It coincides with the first equalizing pulse and never occurs in the even field.
- R8: `hdrive` is high for the first 4 clocks of every line, including lines inside the vertical interval.
- R9: `vdrive` is high during field half lines 0 to 17 (nine lines) of each field and low otherwise.
- R10: A one-clock `vres_eq` moves the position to slot 0 of field half line 0 of the current field. Two clocks after the request is sampled, the outputs show a one-clock equalizing pulse with `vdrive` high.
- R11: A one-clock `vres_vs` moves the position to slot 0 of field half line 6 of the current field. Two clocks after the request is sampled, a broad pulse begins.
- R12: When `vres_eq` and `vres_vs` are both high, `vres_eq` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 32 times the line rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_625 | input | 1 | Line standard select: 0 = 525 lines, 1 = 625 lines |
| vres_eq | input | 1 | Synchronous request: jump to the first pre-equalizing pulse |
| vres_vs | input | 1 | Synchronous request: jump to the first broad vertical pulse |
| csync_n | output | 1 | Composite sync, active low |
| fsync | output | 1 | One-clock marker at the start of the odd field |
| hdrive | output | 1 | Horizontal drive, first 4 clocks of each line |
| vdrive | output | 1 | Vertical drive over the nine-line vertical interval |

## Verification
The hardest cases to reach are the even-field vertical interval in the 625-line standard and the position jumps that happen inside the even field. In the even field the pulse groups sit half a line away from the line grid, and reaching it takes about ten thousand clocks of free running. The stimulus runs a full 525-line frame and a full 625-line frame, so both even fields and both frame lengths are covered. It then fires position requests after seeded random gaps, which lands some of them in each field and some in each pulse group. A cycle-by-cycle model checks the whole waveform, and each request also gets a directed check two and three clocks after it is sampled.

// File: rtl/isg_pkg.sv
package isg_pkg;

   // Segment of a field that the current half line belongs to
   typedef enum logic [1:0] {
      SEG_ACTIVE = 2'd0,
      SEG_EQ     = 2'd1,
      SEG_BROAD  = 2'd2
   } seg_e;

   // Number of pulse groups in a vertical interval: pre-eq, broad, post-eq
   localparam int N_GROUPS = 3;

endpackage

// File: rtl/isg_timebase.sv
module isg_timebase #(
   parameter int HALF_CLKS = 16,
   parameter int HL_A      = 1050,
   parameter int HL_B      = 1250,
   parameter int VS_OFS    = 6,
   localparam int SLOT_W   = $clog2(HALF_CLKS),
   localparam int HL_W     = $clog2(HL_B + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              std_b,
   input  logic              vres_eq,
   input  logic              vres_vs,
   output logic [SLOT_W-1:0] slot,
   output logic [HL_W-1:0]   hl
);

   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(HALF_CLKS - 1);
   localparam logic [HL_W-1:0]   LAST_A    = HL_W'(HL_A - 1);
   localparam logic [HL_W-1:0]   LAST_B    = HL_W'(HL_B - 1);
   localparam logic [HL_W-1:0]   FLD_A     = HL_W'(HL_A / 2);
   localparam logic [HL_W-1:0]   FLD_B     = HL_W'(HL_B / 2);
   localparam logic [HL_W-1:0]   VS_STEP   = HL_W'(VS_OFS);

   logic [HL_W-1:0] fld_start;
   logic [HL_W-1:0] hl_last;
   logic [HL_W-1:0] cur_base;

   always_comb begin
      fld_start = std_b ? FLD_B : FLD_A;
      hl_last   = std_b ? LAST_B : LAST_A;
      cur_base  = (hl >= fld_start) ? fld_start : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot <= '0;
         hl   <= '0;
      end else if (vres_eq) begin
         slot <= '0;
         hl   <= cur_base;
      end else if (vres_vs) begin
         slot <= '0;
         hl   <= cur_base + VS_STEP;
      end else if (slot == SLOT_LAST) begin
         slot <= '0;
         hl   <= (hl >= hl_last) ? '0 : hl + 1'b1;
      end else begin
         slot <= slot + 1'b1;
      end
   end

endmodule

// File: rtl/isg_locator.sv
module isg_locator
   import isg_pkg::*;
#(
   parameter int HL_A      = 1050,
   parameter int HL_B      = 1250,
   parameter int EQ_PULSES = 6,
   parameter int VS_PULSES = 6,
   localparam int HL_W     = $clog2(HL_B + 1)
) (
   input  logic            std_b,
   input  logic [HL_W-1:0] hl,
   output logic [HL_W-1:0] fh,
   output logic            field_odd,
   output logic            line_start,
   output seg_e            seg
);

   localparam logic [HL_W-1:0] FLD_A = HL_W'(HL_A / 2);
   localparam logic [HL_W-1:0] FLD_B = HL_W'(HL_B / 2);

   logic [HL_W-1:0]     fld_start;
   logic [N_GROUPS-1:0] in_grp;

   always_comb begin
      fld_start  = std_b ? FLD_B : FLD_A;
      field_odd  = (hl < fld_start);
      fh         = field_odd ? hl : hl - fld_start;
      line_start = ~hl[0];
   end

   // One range decoder per pulse group of the vertical interval
   for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      localparam int LO = (g == 0) ? 0 : (g == 1) ? EQ_PULSES : EQ_PULSES + VS_PULSES;
      localparam int HI = (g == 1) ? LO + VS_PULSES : LO + EQ_PULSES;
      assign in_grp[g] = (fh >= HL_W'(LO)) && (fh < HL_W'(HI));
   end

   always_comb begin
      if (in_grp[1])                  seg = SEG_BROAD;
      else if (in_grp[0] | in_grp[2]) seg = SEG_EQ;
      else                            seg = SEG_ACTIVE;
   end

endmodule

// File: rtl/isg_shaper.sv
module isg_shaper
   import isg_pkg::*;
#(
   parameter int HALF_CLKS  = 16,
   parameter int HSYNC_CLKS = 2,
   parameter int EQ_CLKS    = 1,
   parameter int SERR_CLKS  = 2,
   parameter int HDRV_CLKS  = 4,
   parameter int VDRV_HL    = 18,
   parameter int HL_W       = 11,
   localparam int SLOT_W    = $clog2(HALF_CLKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] slot,
   input  logic [HL_W-1:0]   fh,
   input  logic              field_odd,
   input  logic              line_start,
   input  seg_e              seg,
   output logic              csync_n,
   output logic              fsync,
   output logic              hdrive,
   output logic              vdrive
);

   localparam logic [SLOT_W-1:0] HS_END = SLOT_W'(HSYNC_CLKS);
   localparam logic [SLOT_W-1:0] EQ_END = SLOT_W'(EQ_CLKS);
   localparam logic [SLOT_W-1:0] BR_END = SLOT_W'(HALF_CLKS - SERR_CLKS);
   localparam logic [SLOT_W-1:0] HD_END = SLOT_W'(HDRV_CLKS);
   localparam logic [HL_W-1:0]   VD_END = HL_W'(VDRV_HL);

   logic sync_low, fs_nx, hd_nx, vd_nx;

   always_comb begin
      unique case (seg)
         SEG_EQ:    sync_low = (slot < EQ_END);
         SEG_BROAD: sync_low = (slot < BR_END);
         default:   sync_low = line_start && (slot < HS_END);
      endcase
      fs_nx = field_odd && (fh == '0) && (slot == '0);
      hd_nx = line_start && (slot < HD_END);
      vd_nx = (fh < VD_END);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csync_n <= 1'b1;
         fsync   <= 1'b0;
         hdrive  <= 1'b0;
         vdrive  <= 1'b0;
      end else begin
         csync_n <= ~sync_low;
         fsync   <= fs_nx;
         hdrive  <= hd_nx;
         vdrive  <= vd_nx;
      end
   end

endmodule

// File: rtl/isync_gen.sv
module isync_gen
   import isg_pkg::*;
#(
   parameter int LINE_CLKS  = 32,
   parameter int HSYNC_CLKS = 2,
   parameter int EQ_CLKS    = 1,
   parameter int SERR_CLKS  = 2,
   parameter int HDRV_CLKS  = 4,
   parameter int EQ_PULSES  = 6,
   parameter int VS_PULSES  = 6,
   parameter int VDRV_LINES = 9,
   parameter int LINES_A    = 525,
   parameter int LINES_B    = 625
) (
   input  logic clk,
   input  logic rst_n,
   input  logic std_625,
   input  logic vres_eq,
   input  logic vres_vs,
   output logic csync_n,
   output logic fsync,
   output logic hdrive,
   output logic vdrive
);

   localparam int HALF_CLKS = LINE_CLKS / 2;
   localparam int SLOT_W    = $clog2(HALF_CLKS);
   localparam int HL_A      = 2 * LINES_A;
   localparam int HL_B      = 2 * LINES_B;
   localparam int HL_W      = $clog2(HL_B + 1);
   localparam int VI_HL     = 2 * EQ_PULSES + VS_PULSES;
   localparam int VDRV_HL   = 2 * VDRV_LINES;

   // Elaboration-time parameter checks
   if (HALF_CLKS * 2 != LINE_CLKS || (HALF_CLKS & (HALF_CLKS - 1)) != 0) begin : g_bad_line
      $error("LINE_CLKS must be twice a power of two");
   end
   if (HSYNC_CLKS >= HALF_CLKS || HDRV_CLKS >= HALF_CLKS || EQ_CLKS >= HALF_CLKS) begin : g_bad_w
      $error("pulse widths must fit inside a half line");
   end
   if (SERR_CLKS < 1 || SERR_CLKS >= HALF_CLKS) begin : g_bad_serr
      $error("serration width out of range");
   end
   if ((LINES_A % 2) == 0 || (LINES_B % 2) == 0 || LINES_B < LINES_A) begin : g_bad_lines
      $error("line counts must be odd with LINES_B >= LINES_A");
   end
   if (VDRV_HL < VI_HL || VDRV_HL >= LINES_A) begin : g_bad_vd
      $error("vertical drive must cover the vertical interval");
   end

   logic [SLOT_W-1:0] slot;
   logic [HL_W-1:0]   hl;
   logic [HL_W-1:0]   fh;
   logic              field_odd;
   logic              line_start;
   seg_e              seg;

   isg_timebase #(
      .HALF_CLKS(HALF_CLKS), .HL_A(HL_A), .HL_B(HL_B), .VS_OFS(EQ_PULSES)
   ) u_tb (
      .clk(clk), .rst_n(rst_n), .std_b(std_625),
      .vres_eq(vres_eq), .vres_vs(vres_vs),
      .slot(slot), .hl(hl)
   );

   isg_locator #(
      .HL_A(HL_A), .HL_B(HL_B), .EQ_PULSES(EQ_PULSES), .VS_PULSES(VS_PULSES)
   ) u_loc (
      .std_b(std_625), .hl(hl), .fh(fh),
      .field_odd(field_odd), .line_start(line_start), .seg(seg)
   );

   isg_shaper #(
      .HALF_CLKS(HALF_CLKS), .HSYNC_CLKS(HSYNC_CLKS), .EQ_CLKS(EQ_CLKS),
      .SERR_CLKS(SERR_CLKS), .HDRV_CLKS(HDRV_CLKS), .VDRV_HL(VDRV_HL), .HL_W(HL_W)
   ) u_shp (
      .clk(clk), .rst_n(rst_n), .slot(slot), .fh(fh),
      .field_odd(field_odd), .line_start(line_start), .seg(seg),
      .csync_n(csync_n), .fsync(fsync), .hdrive(hdrive), .vdrive(vdrive)
   );

endmodule

// File: rtl/isg_checker.sv
module isg_checker (
   input logic clk,
   input logic rst_n,
   input logic vres_eq,
   input logic vres_vs,
   input logic csync_n,
   input logic fsync,
   input logic hdrive,
   input logic vdrive
);

   // R7
   fsync_on_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |-> (!csync_n && vdrive && hdrive));

   // R7
   fsync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> !fsync);

   // R9
   fsync_in_vd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vdrive |-> !fsync);

   // R10
   jump_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vres_eq |=> ##1 (!csync_n && vdrive));

   // R11
   jump_vs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vres_vs && !vres_eq) |=> ##1 (!csync_n && vdrive) ##1 !csync_n);

   // R12
   jump_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vres_vs && vres_eq) |=> ##2 csync_n);

endmodule

bind isync_gen isg_checker u_chk (
   .clk(clk), .rst_n(rst_n), .vres_eq(vres_eq), .vres_vs(vres_vs),
   .csync_n(csync_n), .fsync(fsync), .hdrive(hdrive), .vdrive(vdrive)
);

// File: tb/sim_isync_gen.sv
module sim_isync_gen;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic std_625 = 1'b0;
   logic vres_eq = 1'b0;
   logic vres_vs = 1'b0;
   logic csync_n, fsync, hdrive, vdrive;

   int vectors = 0;
   int errors  = 0;
   int cyc     = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   isync_gen u0 (
      .clk(clk), .rst_n(rst_n), .std_625(std_625),
      .vres_eq(vres_eq), .vres_vs(vres_vs),
      .csync_n(csync_n), .fsync(fsync), .hdrive(hdrive), .vdrive(vdrive)
   );

   // Expected {csync_n, fsync, hdrive, vdrive} for a position (from R3..R9)
   function automatic logic [3:0] f_exp(int hl, int slot, bit b);
      int  fld;
      bit  ev, ls, low;
      int  fh;
      fld = b ? 625 : 525;
      ev  = (hl >= fld);
      fh  = ev ? hl - fld : hl;
      ls  = (hl % 2) == 0;
      if (fh < 6 || (fh >= 12 && fh < 18)) low = (slot < 1);
      else if (fh < 12)                      low = (slot < 14);
      else                                   low = ls && (slot < 2);
      return {~low, (!ev && fh == 0 && slot == 0), ls && (slot < 4), (fh < 18)};
   endfunction

   function automatic string f_tag(int hl, int slot, bit b);
      int fh;
      fh = (hl >= (b ? 625 : 525)) ? hl - (b ? 625 : 525) : hl;
      if (fh < 6 || (fh >= 12 && fh < 18)) return "R4";
      if (fh < 12) return "R5";
      return "R3";
   endfunction

   // Bench position model
   int m_hl = 0, m_slot = 0;
   logic [3:0] m_exp = 4'b1000;
   string m_tag = "R1";

   always @(posedge clk or negedge rst_n) begin
      int base;
      if (!rst_n) begin
         m_hl <= 0; m_slot <= 0; m_exp <= 4'b1000; m_tag <= "R1";
      end else begin
         m_exp <= f_exp(m_hl, m_slot, std_625);
         m_tag <= f_tag(m_hl, m_slot, std_625);
         base = (m_hl >= (std_625 ? 625 : 525)) ? (std_625 ? 625 : 525) : 0;
         if (vres_eq) begin m_hl <= base; m_slot <= 0; end
         else if (vres_vs) begin m_hl <= base + 6; m_slot <= 0; end
         else if (m_slot == 15) begin
            m_slot <= 0;
            m_hl <= (m_hl >= (std_625 ? 1249 : 1049)) ? 0 : m_hl + 1;
         end else m_slot <= m_slot + 1;
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int expv);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Per-cycle comparison against the model
   bit run_cmp = 1'b0;
   always @(negedge clk) begin
      if (run_cmp && rst_n) begin
         chk(csync_n == m_exp[3], m_tag, "csync_n", csync_n, m_exp[3]);
         chk(fsync   == m_exp[2], "R7",  "fsync",   fsync,   m_exp[2]);
         chk(hdrive  == m_exp[1], "R8",  "hdrive",  hdrive,  m_exp[1]);
         chk(vdrive  == m_exp[0], "R9",  "vdrive",  vdrive,  m_exp[0]);
      end
   end

   // Frame period check (R2, R6)
   bit have_last = 1'b0, disturbed = 1'b0;
   int last_fs = 0;
   always @(negedge clk) begin
      if (!rst_n) have_last <= 1'b0;
      else if (fsync) begin
         if (have_last && !disturbed)
            chk((cyc - last_fs) == (std_625 ? 20000 : 16800), "R2", "frame period",
                cyc - last_fs, std_625 ? 20000 : 16800);
         have_last <= 1'b1;
         last_fs   <= cyc;
         disturbed <= 1'b0;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 195000 && !finished) begin
         errors++;
         $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 195000);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(bit b);
      @(negedge clk);
      rst_n = 1'b0; std_625 = b;
      idle(3);
      // R1: idle outputs during reset
      chk(csync_n == 1'b1 && !fsync && !hdrive && !vdrive, "R1", "reset outputs",
          {csync_n, fsync, hdrive, vdrive}, 4'b1000);
      rst_n = 1'b1;
      idle(1);
      // R1: first slot of the odd field after release
      chk({csync_n, fsync, hdrive, vdrive} == 4'b0111, "R1", "first slot",
          {csync_n, fsync, hdrive, vdrive}, 4'b0111);
   endtask

   // Fire a one-clock jump request and check its effect (R10, R11, R12)
   task automatic jump(bit e, bit v);
      @(negedge clk);
      vres_eq = e; vres_vs = v; disturbed = 1'b1;
      @(negedge clk);
      vres_eq = 1'b0; vres_vs = 1'b0;
      @(negedge clk);
      chk(!csync_n && vdrive, e ? "R10" : "R11", "jump target",
          {csync_n, vdrive}, 2'b01);
      @(negedge clk);
      if (e) chk(csync_n == 1'b1, v ? "R12" : "R10", "eq width after jump", csync_n, 1);
      else   chk(csync_n == 1'b0, "R11", "broad pulse after jump", csync_n, 0);
   endtask

   initial begin
      void'($urandom(32'd2024));
      run_cmp = 1'b1;
      // 525-line frame plus its even field (R2..R9, R6 even field mid-line)
      do_reset(1'b0);
      idle(17200);
      // 625-line frame
      do_reset(1'b1);
      idle(20400);
      jump(1'b1, 1'b1);
      // Randomised jumps in both standards
      for (int i = 0; i < 14; i++) begin
         int gap, kind;
         if (i == 7) do_reset(1'b0);
         gap  = 200 + int'($urandom_range(9000));
         kind = int'($urandom_range(2));
         idle(gap);
         case (kind)
            0: jump(1'b1, 1'b0);
            1: jump(1'b0, 1'b1);
            default: jump(1'b1, 1'b1);
         endcase
      end
      idle(21000);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule